// File: doc/BRIEF.md
# 32-bit SEC-DED Check Generator and Checker

This block protects a 32-bit data word with a 7-bit check word using a single-error-correcting, double-error-detecting code. It has two independent, purely combinational paths. The encode path turns a data word into the seven check bits that are stored beside it in memory. The decode path takes the 39-bit word read back from memory. It regenerates the parities, presents a 7-bit syndrome, raises active-low single and multiple error flags, and returns the data word with any single data-bit error repaired.

Every check bit is the parity of a fixed group of 16 data bits. Each data bit feeds either three or five check bits, and no two data bits feed the same set. Any single error therefore leaves an odd, recognisable syndrome, and any double error leaves an even, nonzero one. Some of the stored check bits are inverted when they are written. As a result, a memory that returns all zeros or all ones is reported as an error and never as clean data.

The syndrome is written so that all ones means no error. A low syndrome bit marks a check parity that disagrees with the stored check bit. A single error in the check word is reported as correctable and leaves the data untouched. A syndrome pattern that matches no single position is reported as uncorrectable.

Top module: `ecc39_unit`

## Requirements
- R1: Each encode check bit equals the parity of exactly 16 data bits, XORed with a fixed inversion constant. Every output therefore equals the output for a zero word XORed with the columns of the set data bits, where column j is the encode output for data bit j alone XOR the encode output for zero.
- R2: The 32 data-bit columns are pairwise distinct, and each has exactly 3 or exactly 5 bits set.
- R3: For a word whose check bits come from the encode path, both flags read 1 (no error), the syndrome reads 7'h7F and the data passes unchanged. In general, the syndrome reads all ones exactly when both flags are 1.
- R4: With one flipped data bit j, the decode path returns the original data. The single flag reads 0, the multiple flag reads 1, and the syndrome equals the bitwise inverse of column j. At most one data bit is ever altered.
- R5: With one flipped check bit i, the data passes unchanged, the single flag reads 0 and the multiple flag reads 1. The syndrome is all ones except bit i, which reads 0.
- R6: Any two flipped bits among the 39 drive both flags to 0 and leave the data unchanged. The syndrome then shows an even, nonzero number of zero bits.
- R7: A read word of all zeros, or of all ones (data and check together), drives both flags to 0.
- R8: A syndrome of odd weight that matches no data column and no single check bit is reported as uncorrectable: both flags read 0 and the data passes unchanged.
- R9: The multiple flag never reads 0 while the single flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 32 | Data word to be encoded for a memory write |
| enc_check_o | output | 7 | Check word to store with the data |
| dec_data_i | input | 32 | Data word read from memory |
| dec_check_i | input | 7 | Check word read from memory |
| dec_data_o | output | 32 | Data word after single-bit correction |
| syndrome_o | output | 7 | Syndrome; all ones means no error, a 0 bit marks a failing parity |
| single_err_n_o | output | 1 | Active-low flag: any error detected |
| multi_err_n_o | output | 1 | Active-low flag: uncorrectable error detected |

## Verification
Both paths hold no state, so every result is due in the same cycle as its stimulus. The bench drives a new input just after a rising clock edge and samples all outputs at the following falling edge, half a period later, when the logic has settled. The data-bit columns are measured through the encode path alone. Every decode expectation is then built from those measured columns together with the flip pattern the bench injects. Single and double errors are swept over all 39 positions on random words.

// File: rtl/ecc39_pkg.sv
// Shared constants and code-matrix helpers for the 39-bit SEC-DED unit.
// Assumes a 32-bit data word and a 7-bit check word; the matrix below is
// fixed for these widths.
package ecc39_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;

    // Check bits inverted on generation (bits 3..6, weight four).
    localparam logic [CHK_W-1:0] INV_MASK = 7'h78;

    // Column of the parity matrix for data bit j: the set of check bits
    // that the data bit feeds. Bits 0..23 use weight 3, bits 24..31 weight 5.
    function automatic logic [CHK_W-1:0] column(input int j);
        logic [CHK_W-1:0] c;
        case (j)
            0:  c = 7'h0B;  1:  c = 7'h13;  2:  c = 7'h23;  3:  c = 7'h43;
            4:  c = 7'h15;  5:  c = 7'h25;  6:  c = 7'h45;  7:  c = 7'h29;
            8:  c = 7'h49;  9:  c = 7'h31;  10: c = 7'h51;  11: c = 7'h0E;
            12: c = 7'h16;  13: c = 7'h26;  14: c = 7'h46;  15: c = 7'h1A;
            16: c = 7'h4A;  17: c = 7'h62;  18: c = 7'h1C;  19: c = 7'h2C;
            20: c = 7'h64;  21: c = 7'h38;  22: c = 7'h58;  23: c = 7'h70;
            24: c = 7'h7C;  25: c = 7'h7A;  26: c = 7'h76;  27: c = 7'h6D;
            28: c = 7'h5D;  29: c = 7'h3B;  30: c = 7'h67;  31: c = 7'h1F;
            default: c = '0;
        endcase
        return c;
    endfunction

    // Row of the parity matrix for check bit r: which data bits it covers.
    function automatic logic [DATA_W-1:0] row_mask(input int r);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  c;
        for (int j = 0; j < DATA_W; j++) begin
            c    = column(j);
            m[j] = c[r];
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc39_parity_tree.sv
// Seven parallel parity trees over the data word. Each output bit is the
// XOR of the data bits its matrix row selects (16 inputs per row).
// Purely combinational; no inversion is applied here.
module ecc39_parity_tree
    import ecc39_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] parity_o
);

    // One reduction tree per check bit, row selected at elaboration.
    for (genvar r = 0; r < CW; r++) begin : g_row
        localparam logic [DW-1:0] ROW = row_mask(r);
        assign parity_o[r] = ^(data_i & ROW);
    end

endmodule

// File: rtl/ecc39_locator.sv
// Matches a raw syndrome (1 = failing parity) against every data column
// and every single check position. Each hit vector is at most one-hot
// because all columns are distinct, odd-weight and of weight above one.
module ecc39_locator
    import ecc39_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [CW-1:0] raw_syn_i,
    output logic [DW-1:0] data_hit_o,
    output logic [CW-1:0] check_hit_o
);

    // Exact compare against each data column.
    for (genvar j = 0; j < DW; j++) begin : g_data
        localparam logic [CW-1:0] COL = column(j);
        assign data_hit_o[j] = (raw_syn_i == COL);
    end

    // Exact compare against each one-hot check position.
    for (genvar i = 0; i < CW; i++) begin : g_check
        localparam logic [CW-1:0] ONE = CW'(1) << i;
        assign check_hit_o[i] = (raw_syn_i == ONE);
    end

endmodule

// File: rtl/ecc39_classify.sv
// Turns the raw syndrome and the locator hits into active-low flags.
// Clean: both high. Located single error: single low only. Any other
// nonzero syndrome: both low.
module ecc39_classify #(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input  logic [CW-1:0] raw_syn_i,
    input  logic [DW-1:0] data_hit_i,
    input  logic [CW-1:0] check_hit_i,
    output logic          single_err_n_o,
    output logic          multi_err_n_o
);

    logic any_err;
    logic located;

    // Decide flag levels from syndrome activity and location success.
    always_comb begin
        any_err        = |raw_syn_i;
        located        = (|data_hit_i) | (|check_hit_i);
        single_err_n_o = ~any_err;
        multi_err_n_o  = ~(any_err & ~located);
    end

endmodule

// File: rtl/ecc39_unit.sv
// 39-bit SEC-DED unit: encode path (data -> check word) and decode path
// (data + check -> syndrome, active-low flags, corrected data).
// Both paths are combinational and independent. Stored check bits carry
// INV_MASK so that all-zero and all-one words never decode as clean.
module ecc39_unit
    import ecc39_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] enc_data_i,
    output logic [CW-1:0] enc_check_o,
    input  logic [DW-1:0] dec_data_i,
    input  logic [CW-1:0] dec_check_i,
    output logic [DW-1:0] dec_data_o,
    output logic [CW-1:0] syndrome_o,
    output logic          single_err_n_o,
    output logic          multi_err_n_o
);

    logic [CW-1:0] enc_par;
    logic [CW-1:0] dec_par;
    logic [CW-1:0] raw_syn;
    logic [DW-1:0] data_hit;
    logic [CW-1:0] check_hit;

    ecc39_parity_tree #(.DW(DW), .CW(CW)) u_enc_tree (
        .data_i   (enc_data_i),
        .parity_o (enc_par)
    );

    ecc39_parity_tree #(.DW(DW), .CW(CW)) u_dec_tree (
        .data_i   (dec_data_i),
        .parity_o (dec_par)
    );

    // Stored check word: parities with the fixed inversion applied.
    assign enc_check_o = enc_par ^ INV_MASK;

    // Raw syndrome is 1 where a regenerated parity disagrees; output inverted.
    assign raw_syn    = dec_check_i ^ dec_par ^ INV_MASK;
    assign syndrome_o = ~raw_syn;

    ecc39_locator #(.DW(DW), .CW(CW)) u_locate (
        .raw_syn_i   (raw_syn),
        .data_hit_o  (data_hit),
        .check_hit_o (check_hit)
    );

    ecc39_classify #(.DW(DW), .CW(CW)) u_classify (
        .raw_syn_i      (raw_syn),
        .data_hit_i     (data_hit),
        .check_hit_i    (check_hit),
        .single_err_n_o (single_err_n_o),
        .multi_err_n_o  (multi_err_n_o)
    );

    // Flip only the data bit whose column matched exactly.
    assign dec_data_o = dec_data_i ^ data_hit;

endmodule

// File: rtl/ecc39_unit_chk.sv
// Property checker for ecc39_unit, attached by bind. Relates decode-path
// ports to one another; all checks are immediate and skip unknown values.
module ecc39_unit_chk #(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input logic [DW-1:0] dec_data_i,
    input logic [DW-1:0] dec_data_o,
    input logic [CW-1:0] syndrome_o,
    input logic          single_err_n_o,
    input logic          multi_err_n_o
);

    logic known;

    // Evaluate decode-path relations once all observed values are known.
    always_comb begin
        known = !$isunknown({dec_data_i, dec_data_o, syndrome_o,
                             single_err_n_o, multi_err_n_o});
        if (known) begin
            // R9
            multi_needs_single_chk: assert (multi_err_n_o || !single_err_n_o);
            // R3
            clean_syndrome_chk: assert ((syndrome_o == {CW{1'b1}}) ==
                                        (single_err_n_o && multi_err_n_o));
            // R4
            one_bit_fix_chk: assert ($countones(dec_data_o ^ dec_data_i) <= 1);
            // R6
            no_fix_on_multi_chk: assert (multi_err_n_o || (dec_data_o == dec_data_i));
            // R5
            check_err_passes_chk: assert (($countones(~syndrome_o) != 1) ||
                                          (dec_data_o == dec_data_i));
            // R4
            fix_means_single_chk: assert ((dec_data_o == dec_data_i) ||
                                          (!single_err_n_o && multi_err_n_o));
        end
    end

endmodule

bind ecc39_unit ecc39_unit_chk #(.DW(DW), .CW(CW)) u_chk (
    .dec_data_i     (dec_data_i),
    .dec_data_o     (dec_data_o),
    .syndrome_o     (syndrome_o),
    .single_err_n_o (single_err_n_o),
    .multi_err_n_o  (multi_err_n_o)
);

// File: tb/ecc39_unit_test.sv
// Self-checking bench for ecc39_unit: random words with exhaustive
// single and double flips over all 39 positions plus directed corners.
module ecc39_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [6:0]  enc_check_o;
    logic [31:0] dec_data_i = '0;
    logic [6:0]  dec_check_i = '0;
    logic [31:0] dec_data_o;
    logic [6:0]  syndrome_o;
    logic        single_err_n_o;
    logic        multi_err_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [6:0] base;
    logic [6:0] col [32];

    always #2 clk = ~clk;

    ecc39_unit uut (
        .enc_data_i     (enc_data_i),
        .enc_check_o    (enc_check_o),
        .dec_data_i     (dec_data_i),
        .dec_check_i    (dec_check_i),
        .dec_data_o     (dec_data_o),
        .syndrome_o     (syndrome_o),
        .single_err_n_o (single_err_n_o),
        .multi_err_n_o  (multi_err_n_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive the encoder after a rising edge, return its output at the falling edge.
    task automatic encode(input logic [31:0] d, output logic [6:0] c);
        @(posedge clk);
        enc_data_i = d;
        @(negedge clk);
        c = enc_check_o;
    endtask

    // Drive a 39-bit read word after a rising edge; outputs are sampled at the falling edge.
    task automatic decode(input logic [31:0] d, input logic [6:0] c);
        @(posedge clk);
        dec_data_i  = d;
        dec_check_i = c;
        @(negedge clk);
    endtask

    function automatic logic [6:0] expect_check(input logic [31:0] d);
        logic [6:0] c = base;
        for (int j = 0; j < 32; j++) if (d[j]) c ^= col[j];
        return c;
    endfunction

    initial begin
        logic [6:0]  c;
        logic [31:0] d;
        logic [38:0] w;
        int          dups;
        int          cnt;
        logic [6:0]  free_v;
        bit          found;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state corner: inputs at zero give the all-zero read word (R7).
        @(negedge clk);
        check(!single_err_n_o && !multi_err_n_o, "R7 zero word at start",
              {single_err_n_o, multi_err_n_o}, 2'b00);

        // Measure columns through the encoder only.
        encode(32'h0, base);
        for (int j = 0; j < 32; j++) begin
            encode(32'h1 << j, c);
            col[j] = c ^ base;
        end

        // R2: weights and distinctness.
        for (int j = 0; j < 32; j++)
            check($countones(col[j]) == 3 || $countones(col[j]) == 5,
                  "R2 column weight", col[j], 3);
        dups = 0;
        for (int a = 0; a < 32; a++)
            for (int b = a + 1; b < 32; b++)
                if (col[a] == col[b]) dups++;
        check(dups == 0, "R2 distinct columns", dups, 0);

        // R1: sixteen data bits per check bit, and linearity on random words.
        for (int r = 0; r < 7; r++) begin
            cnt = 0;
            for (int j = 0; j < 32; j++) if (col[j][r]) cnt++;
            check(cnt == 16, "R1 row width", cnt, 16);
        end
        for (int n = 0; n < 200; n++) begin
            d = $urandom();
            encode(d, c);
            check(c == expect_check(d), "R1 encode", c, expect_check(d));
        end

        // R3: clean words.
        for (int n = 0; n < 100; n++) begin
            d = $urandom();
            decode(d, expect_check(d));
            check(single_err_n_o && multi_err_n_o && syndrome_o == 7'h7F &&
                  dec_data_o == d, "R3 clean word",
                  {single_err_n_o, multi_err_n_o, syndrome_o, dec_data_o},
                  {2'b11, 7'h7F, d});
        end

        // R4 and R5: every single flip on several random words.
        for (int n = 0; n < 8; n++) begin
            d = $urandom();
            c = expect_check(d);
            for (int j = 0; j < 32; j++) begin
                decode(d ^ (32'h1 << j), c);
                check(dec_data_o == d && !single_err_n_o && multi_err_n_o &&
                      syndrome_o == ~col[j], "R4 data flip",
                      {single_err_n_o, multi_err_n_o, syndrome_o, dec_data_o},
                      {2'b01, ~col[j], d});
            end
            for (int i = 0; i < 7; i++) begin
                decode(d, c ^ (7'h1 << i));
                check(dec_data_o == d && !single_err_n_o && multi_err_n_o &&
                      syndrome_o == ~(7'h1 << i), "R5 check flip",
                      {single_err_n_o, multi_err_n_o, syndrome_o, dec_data_o},
                      {2'b01, ~(7'h1 << i), d});
            end
        end

        // R6: every pair of flips across the 39 positions.
        d = $urandom();
        for (int a = 0; a < 39; a++) begin
            for (int b = a + 1; b < 39; b++) begin
                w = {expect_check(d), d} ^ (39'h1 << a) ^ (39'h1 << b);
                decode(w[31:0], w[38:32]);
                check(!single_err_n_o && !multi_err_n_o && dec_data_o == w[31:0] &&
                      $countones(~syndrome_o) % 2 == 0 && syndrome_o != 7'h7F,
                      "R6 double flip",
                      {single_err_n_o, multi_err_n_o, syndrome_o, dec_data_o},
                      {2'b00, 7'h00, w[31:0]});
            end
        end

        // R7: gross all-zero and all-one words.
        decode(32'h0, 7'h00);
        check(!single_err_n_o && !multi_err_n_o, "R7 all zeros",
              {single_err_n_o, multi_err_n_o}, 2'b00);
        decode(32'hFFFF_FFFF, 7'h7F);
        check(!single_err_n_o && !multi_err_n_o, "R7 all ones",
              {single_err_n_o, multi_err_n_o}, 2'b00);

        // R8: odd syndrome that matches no position.
        found = 1'b0;
        free_v = '0;
        for (int v = 1; v < 128; v++) begin
            bit used = 1'b0;
            if ($countones(7'(v)) % 2 == 1 && $countones(7'(v)) > 1 && !found) begin
                for (int j = 0; j < 32; j++) if (col[j] == 7'(v)) used = 1'b1;
                if (!used) begin
                    found  = 1'b1;
                    free_v = 7'(v);
                end
            end
        end
        check(found, "R8 unmatched pattern exists", found, 1);
        for (int n = 0; n < 4; n++) begin
            d = $urandom();
            decode(d, expect_check(d) ^ free_v);
            check(!single_err_n_o && !multi_err_n_o && dec_data_o == d &&
                  syndrome_o == ~free_v, "R8 unmatched syndrome",
                  {single_err_n_o, multi_err_n_o, syndrome_o, dec_data_o},
                  {2'b00, ~free_v, d});
        end

        // R9: flag ordering on a random mix of clean, single and double words.
        for (int n = 0; n < 60; n++) begin
            d = $urandom();
            w = {expect_check(d), d};
            if (n % 3 > 0) w ^= 39'h1 << ($urandom() % 39);
            if (n % 3 > 1) w ^= 39'h1 << ($urandom() % 39);
            decode(w[31:0], w[38:32]);
            check(multi_err_n_o || !single_err_n_o, "R9 flag order",
                  {single_err_n_o, multi_err_n_o}, 2'b00);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule